// File: doc/BRIEF.md
# Serial Frame Start Condition Detector

This block decides the moment at which one channel of a synchronous serial port begins moving a data word. It watches a frame-sync level that has already been sampled into the system clock domain. It also watches the channel enable, a strobe that reports the start of the opposite channel, a strobe that reports a new word written into the transmit holding register, and two pattern-compare match strobes. A 4-bit selection input picks one of nine trigger conditions. Once the chosen condition is seen, an 8-bit delay counts down in bit-clock periods, given as a one-cycle `bit_tick` strobe. The block then raises a one-cycle start pulse and reports the channel as busy until the shifter signals the end of the word.

The same module serves both directions. The `TX_MODE` parameter selects the transmit variant: in continuous mode it waits for a written word, and it never chains on compare matches. In the receive variant, a stop-selection input makes a compare-0 start persist: words are received back to back until a compare-1 match ends the sequence. A one-cycle sync flag reports every frame-sync trigger that is detected.

Top module: `frame_start_detect`

## Requirements
- R1: While reset is high, and in the cycle after it falls, `start_pulse`, `sync_flag` and `busy` are 0.
- R2: With selection code 0 (continuous) in the receive variant, a trigger fires in every idle cycle while enabled, so a new start follows each end of transfer.
- R3: In the transmit variant, code 0 triggers only when a word is pending. A `hold_written` pulse marks a word pending from the next cycle. Each continuous trigger uses up one pending word, and a write in the same cycle as that trigger keeps a word pending.
- R4: Code 1 triggers on `peer_start` and code 8 triggers on `cmp0_match`, both sampled while idle.
- R5: Code 2 triggers while `sync_in` is 0, and code 3 triggers while it is 1, in any idle cycle.
- R6: Code 4 triggers when `sync_in` is 0 and its value at the previous clock was 1. Code 5 triggers on the reverse transition. Code 7 triggers when the current and previous values differ. The previous value is tracked on every clock.
- R7: Code 6 triggers when `sync_in` differs from the level it had when the last trigger fired. That reference level is 0 after reset.
- R8: A trigger loads the delay value D. The start pulse appears in the clock cycle after the (D+1)-th `bit_tick` that follows the trigger cycle, so D=0 starts on the first tick.
- R9: `sync_flag` is high for the one cycle after a trigger from codes 2 to 7 fires. It does not rise for other codes.
- R10: Codes 9 to 15 never trigger.
- R11: When `enable` is 0, the detector returns to idle at the next clock and drops any pending delay, busy state and compare chain. The pending-word state of the transmit variant is kept.
- R12: In the receive variant with code 8 and `stop_sel`=1, a compare-0 trigger arms a chain. While the chain is armed, every idle cycle triggers again. `cmp1_match` clears the chain and suppresses a chained trigger in the same cycle. In the transmit variant no chain is armed.
- R13: `start_pulse` lasts one cycle and coincides with `busy` becoming 1. `busy` stays 1 until the clock at which `xfer_done` is sampled, and is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel enable |
| bit_tick | input | 1 | One-cycle strobe per bit-clock period |
| sync_in | input | 1 | Sampled frame-sync level |
| start_sel | input | 4 | Trigger selection code (0 to 8 valid) |
| start_delay | input | DLY_W | Delay in bit periods between trigger and start |
| stop_sel | input | 1 | Receive: keep restarting after compare 0 until compare 1 |
| peer_start | input | 1 | Strobe: the opposite channel started |
| hold_written | input | 1 | Strobe: transmit holding register written |
| cmp0_match | input | 1 | Strobe: compare-0 pattern matched |
| cmp1_match | input | 1 | Strobe: compare-1 pattern matched |
| xfer_done | input | 1 | Strobe: the current word transfer ended |
| start_pulse | output | 1 | One-cycle start-of-data pulse |
| sync_flag | output | 1 | One-cycle flag for a detected frame-sync trigger |
| busy | output | 1 | A transfer is in progress |

## Verification
Trigger detection takes one clock, so `sync_flag` is due in the cycle after the idle cycle in which the condition held. `start_pulse` and `busy` are due in the cycle after the (D+1)-th tick, and `busy` falls one cycle after `xfer_done` is sampled. The bench drives inputs at the falling edge and steps a behavioural model on the rising edge. It compares the registered outputs at the following falling edge, so every expected value carries exactly that one-register latency. Directed checks count `bit_tick` strobes between the trigger and the start. They also count the starts seen over windows chosen to show the effect of invalid codes, of disabling, of the transmit word gate and of the compare chain.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

    localparam int SEL_W = 4;

    localparam logic [SEL_W-1:0] SEL_CONT   = 4'd0;
    localparam logic [SEL_W-1:0] SEL_PEER   = 4'd1;
    localparam logic [SEL_W-1:0] SEL_LOW    = 4'd2;
    localparam logic [SEL_W-1:0] SEL_HIGH   = 4'd3;
    localparam logic [SEL_W-1:0] SEL_FALL   = 4'd4;
    localparam logic [SEL_W-1:0] SEL_RISE   = 4'd5;
    localparam logic [SEL_W-1:0] SEL_CHANGE = 4'd6;
    localparam logic [SEL_W-1:0] SEL_TOGGLE = 4'd7;
    localparam logic [SEL_W-1:0] SEL_CMP0   = 4'd8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2
    } fsd_state_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
        logic toggled;
        logic changed;
    } fsd_sync_ev_t;

    function automatic logic is_sync_code(input logic [SEL_W-1:0] code);
        return (code >= SEL_LOW) && (code <= SEL_TOGGLE);
    endfunction

endpackage

// File: rtl/fsd_sync_watch.sv
module fsd_sync_watch
    import fsd_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         sync_in,
    input  logic         ref_load,
    output fsd_sync_ev_t ev
);
    logic sync_q;
    logic ref_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 1'b0;
            ref_lvl <= 1'b0;
        end else begin
            sync_q <= sync_in;
            if (ref_load) begin
                ref_lvl <= sync_in;
            end
        end
    end

    always_comb begin
        ev.level   = sync_in;
        ev.rise    = sync_in & ~sync_q;
        ev.fall    = ~sync_in & sync_q;
        ev.toggled = sync_in ^ sync_q;
        ev.changed = sync_in ^ ref_lvl;
    end
endmodule

// File: rtl/fsd_trigger_sel.sv
module fsd_trigger_sel
    import fsd_pkg::*;
#(
    parameter bit TX_MODE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             armed,
    input  logic [SEL_W-1:0] start_sel,
    input  logic             stop_sel,
    input  fsd_sync_ev_t     ev,
    input  logic             peer_start,
    input  logic             hold_written,
    input  logic             cmp0_match,
    input  logic             cmp1_match,
    output logic             fire,
    output logic             sync_hit
);
    localparam bit CHAIN_OK = !TX_MODE;

    logic word_pending;
    logic chain;
    logic cont_ok;
    logic src_hit;
    logic chain_go;
    logic chain_set;

    assign cont_ok = TX_MODE ? word_pending : 1'b1;

    always_comb begin
        unique case (start_sel)
            SEL_CONT:   src_hit = cont_ok;
            SEL_PEER:   src_hit = peer_start;
            SEL_LOW:    src_hit = ~ev.level;
            SEL_HIGH:   src_hit = ev.level;
            SEL_FALL:   src_hit = ev.fall;
            SEL_RISE:   src_hit = ev.rise;
            SEL_CHANGE: src_hit = ev.changed;
            SEL_TOGGLE: src_hit = ev.toggled;
            SEL_CMP0:   src_hit = cmp0_match;
            default:    src_hit = 1'b0;
        endcase
    end

    assign chain_go  = chain & ~cmp1_match;
    assign fire      = enable & armed & (src_hit | chain_go);
    assign sync_hit  = enable & armed & src_hit & is_sync_code(start_sel);
    assign chain_set = CHAIN_OK & stop_sel & fire & (start_sel == SEL_CMP0);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_pending <= 1'b0;
            chain        <= 1'b0;
        end else begin
            word_pending <= (word_pending & ~(fire & (start_sel == SEL_CONT)))
                            | hold_written;
            if (!enable || cmp1_match) begin
                chain <= 1'b0;
            end else if (chain_set) begin
                chain <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fsd_start_timer.sv
module fsd_start_timer
    import fsd_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             fire,
    input  logic [DLY_W-1:0] start_delay,
    input  logic             bit_tick,
    input  logic             xfer_done,
    output logic             armed,
    output logic             start_pulse,
    output logic             busy
);
    fsd_state_e       state;
    logic [DLY_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state       <= ST_IDLE;
            remain      <= '0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (fire) begin
                        state  <= ST_WAIT;
                        remain <= start_delay;
                    end
                end
                ST_WAIT: begin
                    if (bit_tick) begin
                        if (remain == '0) begin
                            state       <= ST_XFER;
                            start_pulse <= 1'b1;
                        end else begin
                            remain <= remain - 1'b1;
                        end
                    end
                end
                ST_XFER: begin
                    if (xfer_done) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign armed = (state == ST_IDLE);
    assign busy  = (state == ST_XFER);
endmodule

// File: rtl/frame_start_detect.sv
module frame_start_detect
    import fsd_pkg::*;
#(
    parameter int DLY_W   = 8,
    parameter bit TX_MODE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             bit_tick,
    input  logic             sync_in,
    input  logic [3:0]       start_sel,
    input  logic [DLY_W-1:0] start_delay,
    input  logic             stop_sel,
    input  logic             peer_start,
    input  logic             hold_written,
    input  logic             cmp0_match,
    input  logic             cmp1_match,
    input  logic             xfer_done,
    output logic             start_pulse,
    output logic             sync_flag,
    output logic             busy
);
    fsd_sync_ev_t ev;
    logic         fire;
    logic         sync_hit;
    logic         armed;

    fsd_sync_watch u_watch (
        .clk      (clk),
        .rst      (rst),
        .sync_in  (sync_in),
        .ref_load (fire),
        .ev       (ev)
    );

    fsd_trigger_sel #(.TX_MODE(TX_MODE)) u_trig (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .armed        (armed),
        .start_sel    (start_sel),
        .stop_sel     (stop_sel),
        .ev           (ev),
        .peer_start   (peer_start),
        .hold_written (hold_written),
        .cmp0_match   (cmp0_match),
        .cmp1_match   (cmp1_match),
        .fire         (fire),
        .sync_hit     (sync_hit)
    );

    fsd_start_timer #(.DLY_W(DLY_W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .fire        (fire),
        .start_delay (start_delay),
        .bit_tick    (bit_tick),
        .xfer_done   (xfer_done),
        .armed       (armed),
        .start_pulse (start_pulse),
        .busy        (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_flag <= 1'b0;
        end else begin
            sync_flag <= sync_hit;
        end
    end
endmodule

// File: rtl/fsd_checker.sv
module fsd_checker (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic       bit_tick,
    input logic [3:0] start_sel,
    input logic       start_pulse,
    input logic       sync_flag,
    input logic       busy
);
    // R13
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    // R13
    start_with_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> busy);

    // R13
    busy_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> start_pulse);

    // R8
    start_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> $past(bit_tick));

    // R11
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!busy && !start_pulse && !sync_flag));

    // R9
    sync_code_chk: assert property (@(posedge clk) disable iff (rst)
        sync_flag |-> ($past(start_sel) >= 4'd2 && $past(start_sel) <= 4'd7));
endmodule

bind frame_start_detect fsd_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .bit_tick    (bit_tick),
    .start_sel   (start_sel),
    .start_pulse (start_pulse),
    .sync_flag   (sync_flag),
    .busy        (busy)
);

// File: tb/frame_start_detect_tb_top.sv
`timescale 1ns/1ps
module frame_start_detect_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst = 1'b1;
    logic       en = 1'b0, tick = 1'b0, sync_i = 1'b0, stop = 1'b0;
    logic       peer = 1'b0, hw = 1'b0, cmp0 = 1'b0, cmp1 = 1'b0;
    logic [3:0] sel = 4'd0;
    logic [7:0] dly = 8'd0;
    logic       done_rx = 1'b0, done_tx = 1'b0;
    logic       st_rx, sf_rx, bz_rx, st_tx, sf_tx, bz_tx;

    frame_start_detect #(.DLY_W(8), .TX_MODE(1'b0)) dut_i (
        .clk(clk), .rst(rst), .enable(en), .bit_tick(tick), .sync_in(sync_i),
        .start_sel(sel), .start_delay(dly), .stop_sel(stop), .peer_start(peer),
        .hold_written(hw), .cmp0_match(cmp0), .cmp1_match(cmp1), .xfer_done(done_rx),
        .start_pulse(st_rx), .sync_flag(sf_rx), .busy(bz_rx));

    frame_start_detect #(.DLY_W(8), .TX_MODE(1'b1)) dut_tx_i (
        .clk(clk), .rst(rst), .enable(en), .bit_tick(tick), .sync_in(sync_i),
        .start_sel(sel), .start_delay(dly), .stop_sel(stop), .peer_start(peer),
        .hold_written(hw), .cmp0_match(cmp0), .cmp1_match(cmp1), .xfer_done(done_tx),
        .start_pulse(st_tx), .sync_flag(sf_tx), .busy(bz_tx));

    int tests = 0, fails = 0, cyc = 0, tick_per = 4;
    string cur_req = "R1";
    int starts [2];

    // behavioural reference, index 0 = receive, 1 = transmit
    int m_st [2], m_cnt [2], m_bc [2];
    bit m_chain [2], m_pend [2], m_ref [2], m_prev [2], m_start [2], m_sync [2];

    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) begin
            bit hit, fire, ns, nsy, dn;
            hit = 0; fire = 0; ns = 0; nsy = 0;
            dn = (c == 0) ? done_rx : done_tx;
            if (rst) begin
                m_st[c] = 0; m_cnt[c] = 0; m_bc[c] = 0; m_chain[c] = 0;
                m_pend[c] = 0; m_ref[c] = 0; m_prev[c] = 0;
            end else begin
                if (en) begin
                    if (m_st[c] == 0) begin
                        case (sel)
                            4'd0: hit = (c == 0) ? 1'b1 : m_pend[c];
                            4'd1: hit = peer;
                            4'd2: hit = !sync_i;
                            4'd3: hit = sync_i;
                            4'd4: hit = m_prev[c] && !sync_i;
                            4'd5: hit = !m_prev[c] && sync_i;
                            4'd6: hit = sync_i != m_ref[c];
                            4'd7: hit = sync_i != m_prev[c];
                            4'd8: hit = cmp0;
                            default: hit = 0;
                        endcase
                        fire = hit || (m_chain[c] && !cmp1);
                        nsy = hit && sel >= 2 && sel <= 7;
                        if (fire) begin
                            m_st[c] = 1; m_cnt[c] = int'(dly); m_ref[c] = sync_i;
                        end
                    end else if (m_st[c] == 1) begin
                        if (tick) begin
                            if (m_cnt[c] == 0) begin m_st[c] = 2; ns = 1; end
                            else m_cnt[c]--;
                        end
                    end else if (dn) begin
                        m_st[c] = 0;
                    end
                end else begin
                    m_st[c] = 0; m_cnt[c] = 0;
                end
                if (!en || cmp1) m_chain[c] = 0;
                else if (fire && sel == 4'd8 && stop && c == 0) m_chain[c] = 1;
                m_pend[c] = (m_pend[c] && !(fire && sel == 4'd0)) || hw;
                m_prev[c] = sync_i;
                m_bc[c] = (m_st[c] == 2) ? m_bc[c] + 1 : 0;
            end
            m_start[c] = ns; m_sync[c] = nsy;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic compare();
        if (!rst) begin
            chk(st_rx == m_start[0], {cur_req, " rx start"}, st_rx, m_start[0]);
            chk(sf_rx == m_sync[0],  {cur_req, " rx sync"},  sf_rx, m_sync[0]);
            chk(bz_rx == (m_st[0] == 2), {cur_req, " rx busy"}, bz_rx, m_st[0] == 2);
            chk(st_tx == m_start[1], {cur_req, " tx start"}, st_tx, m_start[1]);
            chk(sf_tx == m_sync[1],  {cur_req, " tx sync"},  sf_tx, m_sync[1]);
            chk(bz_tx == (m_st[1] == 2), {cur_req, " tx busy"}, bz_tx, m_st[1] == 2);
            starts[0] += int'(st_rx);
            starts[1] += int'(st_tx);
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare();
        cyc++;
        tick = (tick_per <= 1) ? 1'b1 : ((cyc % tick_per) == 0);
        done_rx = (m_st[0] == 2) && (m_bc[0] >= 3);
        done_tx = (m_st[1] == 2) && (m_bc[1] >= 3);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic rearm();
        en = 1'b0; step(); en = 1'b1;
    endtask

    bit finished = 0;

    initial begin
        int s0, s1, nt;
        run(3);
        rst = 1'b0;
        step();
        cur_req = "R1";
        chk(!st_rx && !sf_rx && !bz_rx, "R1 rx outputs after reset", {st_rx, sf_rx, bz_rx}, 0);
        chk(!st_tx && !sf_tx && !bz_tx, "R1 tx outputs after reset", {st_tx, sf_tx, bz_tx}, 0);

        // continuous receive and the transmit word gate
        cur_req = "R2"; sel = 4'd0; dly = 8'd0; en = 1'b1;
        s0 = starts[0]; s1 = starts[1];
        run(80);
        chk(starts[0] - s0 >= 2, "R2 rx continuous restarts", starts[0] - s0, 2);
        chk(starts[1] - s1 == 0, "R3 tx idle without word", starts[1] - s1, 0);
        cur_req = "R3"; s1 = starts[1];
        hw = 1'b1; step(); hw = 1'b0;
        run(80);
        chk(starts[1] - s1 == 1, "R3 tx one start per word", starts[1] - s1, 1);

        // delay measured in ticks
        for (int d = 0; d < 4; d++) begin
            cur_req = "R8"; sel = 4'd1; dly = 8'(d); tick_per = 3;
            rearm(); run(2);
            peer = 1'b1; nt = 0;
            for (int i = 0; i < 200; i++) begin
                step(); peer = 1'b0;
                if (st_rx) break;
                if (tick) nt++;
            end
            chk(nt == d + 1, "R8 ticks from trigger to start", nt, d + 1);
            run(10);
        end

        // compare-0 and peer codes
        cur_req = "R4"; sel = 4'd8; dly = 8'd1; stop = 1'b0; rearm();
        s0 = starts[0];
        cmp0 = 1'b1; step(); cmp0 = 1'b0; run(30);
        peer = 1'b1; step(); peer = 1'b0; run(30);
        chk(starts[0] - s0 == 1, "R4 compare-0 single start", starts[0] - s0, 1);

        // level, edge and change codes with a toggling frame sync
        for (int code = 2; code <= 7; code++) begin
            cur_req = (code <= 3) ? "R5" : (code == 6) ? "R7" : "R6";
            sel = 4'(code); dly = 8'(code % 2); tick_per = 2; rearm();
            for (int i = 0; i < 120; i++) begin
                if ((i % 7) == 0 || (i % 11) == 0) sync_i = ~sync_i;
                step();
            end
            cur_req = "R9"; run(20);
        end

        // invalid codes
        cur_req = "R10"; s0 = starts[0]; s1 = starts[1];
        for (int code = 9; code <= 15; code++) begin
            sel = 4'(code); rearm();
            for (int i = 0; i < 40; i++) begin
                sync_i = (i % 3) == 0; peer = (i % 5) == 0; cmp0 = (i % 6) == 0;
                step();
            end
            peer = 1'b0; cmp0 = 1'b0;
        end
        chk(starts[0] - s0 == 0, "R10 rx no start", starts[0] - s0, 0);
        chk(starts[1] - s1 == 0, "R10 tx no start", starts[1] - s1, 0);

        // disable cancels a pending delay
        cur_req = "R11"; sel = 4'd1; dly = 8'd200; tick_per = 1; rearm(); run(2);
        s0 = starts[0]; s1 = starts[1];
        peer = 1'b1; step(); peer = 1'b0; run(50);
        en = 1'b0; run(2); en = 1'b1; run(400);
        chk(starts[0] - s0 == 0, "R11 rx delay cancelled", starts[0] - s0, 0);
        chk(starts[1] - s1 == 0, "R11 tx delay cancelled", starts[1] - s1, 0);

        // compare chain
        cur_req = "R12"; sel = 4'd8; dly = 8'd0; stop = 1'b1; tick_per = 2; rearm();
        s0 = starts[0]; s1 = starts[1];
        cmp0 = 1'b1; step(); cmp0 = 1'b0; run(100);
        chk(starts[0] - s0 >= 3, "R12 rx chained restarts", starts[0] - s0, 3);
        chk(starts[1] - s1 == 1, "R12 tx no chain", starts[1] - s1, 1);
        cmp1 = 1'b1; step(); cmp1 = 1'b0; run(40);
        s0 = starts[0]; run(60);
        chk(starts[0] - s0 == 0, "R12 chain stopped by compare-1", starts[0] - s0, 0);
        stop = 1'b0;

        // mixed stimulus
        cur_req = "R13"; tick_per = 3;
        for (int seg = 0; seg < 12; seg++) begin
            sel = 4'($urandom_range(0, 15)); dly = 8'($urandom_range(0, 3));
            stop = 1'($urandom_range(0, 1));
            for (int i = 0; i < 200; i++) begin
                if ($urandom_range(0, 5) == 0) sync_i = ~sync_i;
                peer = ($urandom_range(0, 19) == 0);
                cmp0 = ($urandom_range(0, 24) == 0);
                cmp1 = ($urandom_range(0, 29) == 0);
                hw   = ($urandom_range(0, 14) == 0);
                if ($urandom_range(0, 149) == 0) en = ~en;
                step();
            end
        end
        peer = 0; cmp0 = 0; cmp1 = 0; hw = 0;
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule